// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns a byte stream of frame contents (address, control and information octets) into a serial HDLC bit stream. Octets arrive on a valid/ready interface with a last marker on the final octet of each frame. The block shifts out one bit on every cycle where the bit-enable input is high. While no frame is waiting, the line carries either continuous ones or back-to-back flags, as set by a mode input. Each frame is preceded by a configurable number of flags. It is followed by a 16-bit or 32-bit frame check sequence and one closing flag. A zero is inserted after every run of five ones in the frame body and in the check sequence.

The block is built from three parts. A bit shifter does the zero insertion. A check-sequence generator computes the CRC. An octet-level sequencer picks the next 8-bit unit to send at each octet boundary. A frame can be cut short on command. It is also cut short when the source runs dry in mid-frame, which raises a one-cycle status pulse.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While rst_ni is low or en_i is low, txd_o is 1 and ready_o is 0. The line state is cleared, so that after enable the sequencer starts in idle with no flag history.
- R2: In idle with no octet offered, the block sends 0x7E flags when cfg_idle_flags_i is 1 and 0xFF octets when it is 0. These octets go out LSB first with no zero insertion.
- R3: When an octet is offered in idle and the last unit sent was a flag, cfg_min_flags_i further flags are sent before the first data octet. When the last unit was not a flag, one opening flag is sent and then cfg_min_flags_i further flags. With a setting of 0, one flag closes a frame and also opens the next one.
- R4: Data octets are sent LSB first. txd_o changes only on a clock edge where en_i and bit_en_i were both high.
- R5: After the octet marked by last_i, the check sequence is sent and then exactly one closing flag 0x7E. After that the block is back in idle.
- R6: The check sequence runs over the transmitted data bit order. It uses the polynomial 0x1021 (16-bit, cfg_crc32_i=0) or 0x04C11DB7 (32-bit, cfg_crc32_i=1). The register is preset to all ones, and its ones' complement is sent with the most significant octet first and each octet MSB first.
- R7: A 0 is inserted after every five consecutive 1s in data and check-sequence bits, including runs that cross an octet boundary. No zero is inserted in flags, idle octets or abort octets.
- R8: An abort_i pulse while data or check-sequence octets are being sent ends the frame at the next octet boundary. The block then sends one 0xFF octet with no zero insertion and returns to idle. The next accepted octet starts a new frame.
- R9: If no octet is offered at a mid-frame data boundary, the frame is aborted as in R8, and underrun_o is high for exactly the one cycle after that boundary.
- R10: ready_o is high only in a cycle where a data octet would be loaded. It is never high while preamble flags are still pending, nor during the check sequence, the closing flag or an abort. An octet is taken when valid_i and ready_o are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; low clears the line state |
| bit_en_i | input | 1 | One output bit per cycle with this high |
| cfg_idle_flags_i | input | 1 | Idle fill: 1 flags, 0 ones |
| cfg_min_flags_i | input | FLAG_CNT_W | Extra flags before each frame (0..15) |
| cfg_crc32_i | input | 1 | Check sequence width: 1 = 32-bit, 0 = 16-bit |
| abort_i | input | 1 | Abort the frame in progress |
| data_i | input | 8 | Frame octet |
| valid_i | input | 1 | data_i holds an octet |
| last_i | input | 1 | data_i is the final octet of its frame |
| ready_o | output | 1 | Octet taken this cycle if valid_i is high |
| txd_o | output | 1 | Serial line output |
| underrun_o | output | 1 | One-cycle pulse on a mid-frame source underrun |

## Verification
The bench builds the block with the default FLAG_CNT_W of 4. This lets it drive both ends of the preamble range: a setting of 0, where a single flag is shared between back-to-back frames, and a setting of 15. It runs both check-sequence widths in both idle modes. The bit enable is driven either every cycle or every third cycle, so the bench also sees txd_o held still between bit ticks. The octet values are chosen so that runs of five ones fall inside an octet, across an octet boundary and on the data octet 0x7E, which must not be read as a flag.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int          OCT_W    = 8;
  localparam logic [7:0]  FLAG_OCT = 8'h7E;
  localparam logic [7:0]  ONES_OCT = 8'hFF;
  localparam logic [15:0] POLY16   = 16'h1021;
  localparam logic [31:0] POLY32   = 32'h04C11DB7;

  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_DATA, ST_CRC, ST_CLOSE} tx_st_e;

  // one octet through the MSB-feedback register, data bits in line order (LSB first)
  function automatic logic [31:0] crc_octet(input logic [31:0] c, input logic [7:0] d,
                                            input logic wide);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = (wide ? r[31] : r[15]) ^ d[i];
      r  = r << 1;
      if (fb) r = r ^ (wide ? POLY32 : {16'h0, POLY16});
    end
    return r;
  endfunction
endpackage

// File: rtl/hdlc_fcs_gen.sv
module hdlc_fcs_gen
  import hdlc_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             preset_i,
  input  logic             step_i,
  input  logic             wide_i,
  input  logic [OCT_W-1:0] data_i,
  input  logic [1:0]       sel_i,
  output logic [OCT_W-1:0] oct_o
);
  logic [31:0]      crc_q;
  logic [4:0]       sh;
  logic [OCT_W-1:0] raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                crc_q <= '1;
    else if (clr_i || preset_i) crc_q <= '1;
    else if (step_i)            crc_q <= crc_octet(crc_q, data_i, wide_i);
  end

  // octet sel_i counted from the most significant end of the active width
  always_comb begin
    sh  = wide_i ? {~sel_i, 3'b000} : {2'b00, ~sel_i[0], 3'b000};
    raw = ~crc_q[sh +: OCT_W];
    // reversed so that an LSB-first shifter emits it MSB first
    for (int i = 0; i < OCT_W; i++) oct_o[i] = raw[OCT_W-1-i];
  end
endmodule

// File: rtl/hdlc_bit_shifter.sv
module hdlc_bit_shifter #(
  parameter int OCT_W   = 8,
  parameter int RUN_MAX = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [OCT_W-1:0] load_i,
  input  logic             load_stuff_i,
  output logic             need_load_o,
  output logic             txd_o
);
  localparam int CNT_W = $clog2(OCT_W + 1);
  localparam int RUN_W = $clog2(RUN_MAX + 1);

  logic [OCT_W-1:0] sh_q, cur;
  logic [CNT_W-1:0] left_q;
  logic [RUN_W-1:0] ones_q;
  logic             stuff_q, sfy_q, cur_sfy, txd_q;

  assign need_load_o = (left_q == '0) && !stuff_q;
  assign cur         = need_load_o ? load_i : sh_q;
  assign cur_sfy     = need_load_o ? load_stuff_i : sfy_q;
  assign txd_o       = txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; left_q <= '0; ones_q <= '0; stuff_q <= 1'b0; sfy_q <= 1'b0; txd_q <= 1'b1;
    end else if (clr_i) begin
      sh_q <= '0; left_q <= '0; ones_q <= '0; stuff_q <= 1'b0; sfy_q <= 1'b0; txd_q <= 1'b1;
    end else if (adv_i) begin
      if (stuff_q) begin
        txd_q   <= 1'b0;
        stuff_q <= 1'b0;
        ones_q  <= '0;
      end else begin
        txd_q  <= cur[0];
        sh_q   <= cur >> 1;
        left_q <= need_load_o ? CNT_W'(OCT_W - 1) : left_q - 1'b1;
        sfy_q  <= cur_sfy;
        if (cur_sfy && cur[0]) begin
          if (ones_q == RUN_W'(RUN_MAX - 1)) begin
            stuff_q <= 1'b1;
            ones_q  <= '0;
          end else begin
            ones_q <= ones_q + 1'b1;
          end
        end else begin
          ones_q <= '0;
        end
      end
    end
  end

  // R7: a pending insertion puts a zero on the line at the next tick
  assert_stuff_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stuff_q && adv_i && !clr_i) |=> !txd_o);
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int FLAG_CNT_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  bit_en_i,
  input  logic                  cfg_idle_flags_i,
  input  logic [FLAG_CNT_W-1:0] cfg_min_flags_i,
  input  logic                  cfg_crc32_i,
  input  logic                  abort_i,
  input  logic [OCT_W-1:0]      data_i,
  input  logic                  valid_i,
  input  logic                  last_i,
  output logic                  ready_o,
  output logic                  txd_o,
  output logic                  underrun_o
);
  tx_st_e                st_q, st_d;
  logic [FLAG_CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]            idx_q, idx_d, crc_last;
  logic                  prev_flag_q, abort_req_q, underrun_q;
  logic                  adv, clr, act, need_load, in_frame, abort_now, slot;
  logic                  take, urun, crc_keep, unit_stuff, unit_flag;
  logic [OCT_W-1:0]      unit_byte, fcs_oct;

  assign clr       = !en_i;
  assign adv       = en_i && bit_en_i;
  assign act       = adv && need_load;
  assign in_frame  = (st_q == ST_DATA) || (st_q == ST_CRC);
  assign abort_now = in_frame && (abort_req_q || abort_i);
  assign crc_last  = cfg_crc32_i ? 2'd3 : 2'd1;
  assign slot      = ((st_q == ST_DATA) && !abort_now)
                  || ((st_q == ST_PRE) && (cnt_q == '0))
                  || ((st_q == ST_IDLE) && prev_flag_q && (cfg_min_flags_i == '0));
  assign ready_o    = act && slot;
  assign underrun_o = underrun_q;

  always_comb begin
    unit_byte = FLAG_OCT; unit_stuff = 1'b0; unit_flag = 1'b1;
    st_d = st_q; cnt_d = cnt_q; idx_d = idx_q;
    take = 1'b0; urun = 1'b0; crc_keep = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (slot && valid_i) take = 1'b1;
        else if (valid_i) begin
          st_d  = ST_PRE;
          cnt_d = prev_flag_q ? cfg_min_flags_i - 1'b1 : cfg_min_flags_i;
        end else if (!cfg_idle_flags_i) begin
          unit_byte = ONES_OCT; unit_flag = 1'b0;
        end
      end
      ST_PRE: begin
        if (cnt_q == '0) take = valid_i;
        else cnt_d = cnt_q - 1'b1;
      end
      ST_DATA: begin
        if (!abort_now && valid_i) take = 1'b1;
        else begin
          unit_byte = ONES_OCT; unit_flag = 1'b0; st_d = ST_IDLE;
          urun = !abort_now;
        end
      end
      ST_CRC: begin
        if (abort_now) begin
          unit_byte = ONES_OCT; unit_flag = 1'b0; st_d = ST_IDLE;
        end else begin
          unit_byte = fcs_oct; unit_stuff = 1'b1; unit_flag = 1'b0; crc_keep = 1'b1;
          idx_d = idx_q + 1'b1;
          if (idx_q == crc_last) st_d = ST_CLOSE;
        end
      end
      default: st_d = ST_IDLE;  // ST_CLOSE sends the default flag
    endcase
    if (take) begin
      unit_byte = data_i; unit_stuff = 1'b1; unit_flag = 1'b0; idx_d = '0;
      st_d = last_i ? ST_CRC : ST_DATA;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || clr) begin
      st_q <= ST_IDLE; cnt_q <= '0; idx_q <= '0;
      prev_flag_q <= 1'b0; abort_req_q <= 1'b0; underrun_q <= 1'b0;
    end else begin
      if (act) begin
        st_q <= st_d; cnt_q <= cnt_d; idx_q <= idx_d; prev_flag_q <= unit_flag;
      end
      abort_req_q <= act ? 1'b0 : (abort_req_q || (abort_i && in_frame));
      underrun_q  <= act && urun;
    end
  end

  hdlc_fcs_gen u_fcs (
    .clk_i, .rst_ni, .clr_i(clr),
    .preset_i(act && !take && !crc_keep), .step_i(act && take),
    .wide_i(cfg_crc32_i), .data_i(data_i), .sel_i(idx_q), .oct_o(fcs_oct)
  );

  hdlc_bit_shifter #(.OCT_W(OCT_W)) u_shift (
    .clk_i, .rst_ni, .clr_i(clr), .adv_i(adv),
    .load_i(unit_byte), .load_stuff_i(unit_stuff),
    .need_load_o(need_load), .txd_o(txd_o)
  );

  assert_off_line_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> txd_o);
  assert_hold_between_ticks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bit_en_i) |=> $stable(txd_o));
  assert_underrun_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !underrun_o);
  assert_ready_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
endmodule

// File: tb/hdlc_tx_framer_tb.sv
module hdlc_tx_framer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni, en_i, bit_en_i, cfg_idle_flags_i, cfg_crc32_i, abort_i;
  logic [3:0] cfg_min_flags_i;
  logic [7:0] data_i;
  logic       valid_i, last_i, ready_o, txd_o, underrun_o;

  always #5 clk_i = ~clk_i;

  hdlc_tx_framer #(.FLAG_CNT_W(4)) dut_i (.*);

  int nvec = 0, nerr = 0, cyc = 0, be_div = 1;
  logic b_en = 0, b_idle_flags = 0, b_crc32 = 0, abort_pend = 0;
  logic [3:0] b_min = 0;
  logic [7:0] src_d[$];
  logic       src_l[$];
  // reference model state
  int m_st = 0, m_cnt = 0, m_ones = 0;
  logic m_prev_flag = 0, m_abort_req = 0;
  logic bitq[$];
  string tagq[$];
  logic fbits[$];
  logic [7:0] crcq[$];
  logic exp_txd = 1, exp_urun = 0, exp_ready = 0;
  string cur_tag = "R1 reset";

  task automatic fail(string tag, int got, int exp);
    nerr++;
    $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  task automatic push_unit(logic [7:0] b, logic stuff, logic msb_first, string tag);
    for (int i = 0; i < 8; i++) begin
      logic x;
      x = msb_first ? b[7-i] : b[i];
      bitq.push_back(x); tagq.push_back(tag);
      if (stuff && x) begin
        m_ones++;
        if (m_ones == 5) begin bitq.push_back(1'b0); tagq.push_back("R7 inserted zero"); m_ones = 0; end
      end else m_ones = 0;
    end
  endtask

  task automatic build_crc();
    logic [31:0] c, poly;
    int w;
    w = b_crc32 ? 32 : 16;
    poly = b_crc32 ? 32'h04C11DB7 : 32'h00001021;
    c = 32'hFFFFFFFF;
    foreach (fbits[i]) begin
      logic fb;
      fb = c[w-1] ^ fbits[i];
      c = c << 1;
      if (fb) c = c ^ poly;
    end
    c = ~c;
    crcq.delete();
    for (int k = 0; k < w/8; k++) crcq.push_back(8'(c >> (w - 8 - 8*k)));
  endtask

  task automatic take_data();
    logic [7:0] d; logic l;
    d = src_d.pop_front(); l = src_l.pop_front();
    if (m_st != 2) fbits.delete();
    push_unit(d, 1, 0, "R4 data octet");
    for (int i = 0; i < 8; i++) fbits.push_back(d[i]);
    if (l) begin build_crc(); m_st = 3; end else m_st = 2;
    m_prev_flag = 0;
  endtask

  task automatic do_abort(string tag);
    push_unit(8'hFF, 0, 0, tag);
    m_st = 0; m_prev_flag = 0;
  endtask

  task automatic decide(logic aeff);
    case (m_st)
      0: if (valid_i && m_prev_flag && b_min == 0) take_data();
         else if (valid_i) begin
           m_cnt = m_prev_flag ? int'(b_min) - 1 : int'(b_min);
           push_unit(8'h7E, 0, 0, "R3 opening flag"); m_st = 1; m_prev_flag = 1;
         end else if (b_idle_flags) begin push_unit(8'h7E, 0, 0, "R2 idle flag"); m_prev_flag = 1; end
         else begin push_unit(8'hFF, 0, 0, "R2 idle ones"); m_prev_flag = 0; end
      1: if (m_cnt == 0 && valid_i) take_data();
         else begin
           push_unit(8'h7E, 0, 0, "R3 preamble flag"); m_prev_flag = 1;
           if (m_cnt > 0) m_cnt--;
         end
      2: if (aeff) begin
           do_abort("R8 abort ones");
           while (src_l.size() > 0) begin logic l; void'(src_d.pop_front()); l = src_l.pop_front(); if (l) break; end
         end else if (valid_i) take_data();
         else begin do_abort("R9 underrun ones"); exp_urun = 1; end
      3: if (aeff) begin
           do_abort("R8 abort ones");
           while (src_l.size() > 0) begin logic l; void'(src_d.pop_front()); l = src_l.pop_front(); if (l) break; end
         end else begin
           push_unit(crcq.pop_front(), 1, 1, "R6 check sequence");
           if (crcq.size() == 0) m_st = 4;
         end
      default: begin push_unit(8'h7E, 0, 0, "R5 closing flag"); m_st = 0; m_prev_flag = 1; end
    endcase
  endtask

  task automatic step();
    logic adv, bnd, aeff, slot, infr;
    @(negedge clk_i);
    nvec++; if (txd_o !== exp_txd) fail(cur_tag, txd_o, exp_txd);
    nvec++; if (underrun_o !== exp_urun) fail("R9 underrun pulse", underrun_o, exp_urun);
    cyc++;
    en_i = b_en; cfg_idle_flags_i = b_idle_flags; cfg_min_flags_i = b_min; cfg_crc32_i = b_crc32;
    bit_en_i = (be_div <= 1) ? 1'b1 : ((cyc % be_div) == 0);
    valid_i = src_d.size() > 0;
    data_i = valid_i ? src_d[0] : 8'h00;
    last_i = valid_i ? src_l[0] : 1'b0;
    abort_i = abort_pend; abort_pend = 0;
    #1;
    adv  = en_i && bit_en_i;
    bnd  = bitq.size() == 0;
    infr = (m_st == 2) || (m_st == 3);
    aeff = infr && (m_abort_req || abort_i);
    slot = (m_st == 2 && !aeff) || (m_st == 1 && m_cnt == 0) || (m_st == 0 && m_prev_flag && b_min == 0);
    exp_ready = adv && bnd && slot;
    nvec++; if (ready_o !== exp_ready) fail("R10 ready", ready_o, exp_ready);
    exp_urun = 0;
    if (!en_i) begin
      m_st = 0; m_cnt = 0; m_ones = 0; m_prev_flag = 0; m_abort_req = 0;
      bitq.delete(); tagq.delete(); exp_txd = 1; cur_tag = "R1 disabled";
    end else begin
      if (adv) begin
        if (bnd) decide(aeff);
        exp_txd = bitq.pop_front(); cur_tag = tagq.pop_front();
      end
      if (adv && bnd) m_abort_req = 0;
      else if (infr && abort_i) m_abort_req = 1;
    end
    if (cyc >= 150000) begin fail("watchdog", cyc, 0); finish_run(); end
  endtask

  task automatic add(logic [7:0] d, logic l);
    src_d.push_back(d); src_l.push_back(l);
  endtask

  task automatic wait_idle(int extra);
    while (src_d.size() > 0 || m_st != 0 || bitq.size() != 0) step();
    repeat (extra) step();
  endtask

  initial begin
    rst_ni = 0; en_i = 0; bit_en_i = 0; cfg_idle_flags_i = 0; cfg_min_flags_i = 0;
    cfg_crc32_i = 0; abort_i = 0; data_i = 0; valid_i = 0; last_i = 0;
    repeat (3) begin
      @(negedge clk_i);
      nvec++; if (txd_o !== 1'b1) fail("R1 reset txd", txd_o, 1);
      nvec++; if (ready_o !== 1'b0) fail("R1 reset ready", ready_o, 0);
    end
    rst_ni = 1;
    repeat (5) step();                      // R1 disabled line
    // idle ones, two extra flags, 16-bit check, stuffing across octets
    b_en = 1; b_idle_flags = 0; b_min = 2; b_crc32 = 0; be_div = 1;
    repeat (20) step();                     // R2 ones
    add(8'h03, 0); add(8'hF8, 0); add(8'hFF, 0); add(8'h7E, 0); add(8'h3F, 1);
    wait_idle(24);
    // flag idle, zero extra flags, back-to-back frames, 32-bit check, slow ticks
    b_idle_flags = 1; b_min = 0; b_crc32 = 1; be_div = 3;
    repeat (40) step();                     // R2 flags, R4 hold
    add(8'hA5, 0); add(8'h1F, 1);
    add(8'hFF, 0); add(8'hFF, 0); add(8'h00, 1);
    wait_idle(60);
    // maximum preamble from ones idle
    b_idle_flags = 0; b_min = 15; b_crc32 = 0; be_div = 1;
    add(8'h55, 0); add(8'hF0, 1);
    wait_idle(20);
    // abort mid-frame, then a clean frame
    b_min = 1; b_crc32 = 1;
    for (int i = 0; i < 16; i++) add(8'(i * 37 + 5), i == 15);
    while (m_st != 2) step();
    repeat (30) step();
    abort_pend = 1;                         // R8
    step();
    add(8'h81, 1);
    wait_idle(20);
    // underrun after three octets
    b_idle_flags = 1; b_min = 3; b_crc32 = 0;
    add(8'h11, 0); add(8'hFE, 0); add(8'h7F, 0);   // R9
    wait_idle(20);
    add(8'hC3, 1);
    wait_idle(20);
    // disable mid-frame, then idle again
    for (int i = 0; i < 6; i++) add(8'hF7, i == 5);
    while (m_st != 2) step();
    b_en = 0;
    src_d.delete(); src_l.delete();
    repeat (10) step();                     // R1
    b_en = 1;
    repeat (30) step();
    finish_run();
  end
endmodule